// File: doc/BRIEF.md
# Interleaved Stream Corner-Turn Buffer

This block sits between a wide sample stream and a row of per-instance processing kernels. Every input beat is 64 bits and holds two complex samples (16-bit real, 16-bit imaginary) from two different signal instances, one in each 32-bit lane. Consecutive beats rotate through four time slots, so one buffer half holds 2 lanes × 4 slots = 8 instances of POINTS samples each. The block writes beats into a double-banked store and, once a half is full, drains it on four consumer streams. Consumer port k carries slot k: first every point of lane 0, then every point of lane 1, with a last flag closing each instance.

A mirror path takes the per-port results back. Each port writes its samples to the same lane, slot and point positions in a second double-banked store. Full halves are read back out as 64-bit beats in the original order: lane-packed, slot fastest, then point. Every edge is a valid/ready stream. Filling and draining run on opposite halves at the same time, and a half changes role only when its writer has filled it and every reader has emptied the other half.

Top module: `ilv_corner_turn`

## Requirements
- R1: After synchronous reset, in_ready and all bits of res_ready are 1, and cons_valid and out_valid are 0.
- R2: Within a half, the accepted input beat number n (counting from 0) is stored at slot n mod 4 and point n div 4. Lane 0 is in_data[31:0] and lane 1 is in_data[63:32]. A half is complete after 4 × POINTS beats.
- R3: Consumer port k emits only slot k of a completed half, in this order: lane 0 for points 0..POINTS-1, then lane 1 for points 0..POINTS-1.
- R4: cons_last[k] is 1 exactly on the sample of point POINTS-1 of each lane.
- R5: While the consumers drain one half, the input keeps filling the other half.
- R6: in_ready goes to 0 right after the beat that completes a half, and it stays 0 until every consumer port has issued all of its samples from the other half.
- R7: Result port k accepts 2 × POINTS samples per half, lane 0 points first and then lane 1 points. These land at slot k. res_ready[k] then stays 0 until the next bank swap.
- R8: Output beats carry, per half, slot fastest and then point, with lane 0 in out_data[31:0]. A consumer-to-result identity loop therefore reproduces the input beat sequence exactly.
- R9: A consumer port holding valid without ready keeps its data and last flag unchanged in the next cycle.
- R10: An output beat holding valid without ready keeps its data unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| in_data | input | LANES×SW | Two lane-packed samples |
| cons_valid | output | SLOTS | Per-port consumer sample valid |
| cons_ready | input | SLOTS | Per-port consumer ready |
| cons_data | output | SLOTS×SW | Per-port consumer sample |
| cons_last | output | SLOTS | Final point of an instance |
| res_valid | input | SLOTS | Per-port result sample valid |
| res_ready | output | SLOTS | Per-port result ready |
| res_data | input | SLOTS×SW | Per-port result sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted when high |
| out_data | output | LANES×SW | Lane-packed output beat |

## Verification
Two things can share a clock edge: a beat written into the filling half, and reads of the draining half on all four consumer ports. In the mirror path the same holds for result writes and beat reads. The bench first stalls every consumer to fill both halves. It then releases them under random stalls and gaps, and finally runs a gap-free phase in which every edge carries writes and reads on opposite banks. The exact per-port sample order, the last flags and the round-trip beat sequence are the evidence that no read saw a half still being written.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int SAMPLE_W_DEF = 32;
  localparam int LANES_DEF    = 2;
  localparam int SLOTS_DEF    = 4;
  localparam int POINTS_DEF   = 64;

  // index width that never collapses to zero
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ct_sdp_ram.sv
module ct_sdp_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 128,
  localparam int AW   = ct_pkg::idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ct_pingpong_ctrl.sv
module ct_pingpong_ctrl #(
  parameter int NF = 1,
  parameter int ND = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] fill_done,
  input  logic [ND-1:0] drain_done,
  output logic          fill_bank,
  output logic          drain_bank,
  output logic [NF-1:0] fill_hold,
  output logic [ND-1:0] drain_act
);
  logic          bank_q;
  logic [NF-1:0] filled_q;
  logic [ND-1:0] left_q;
  logic          swap;

  assign swap = (&filled_q) && !(|left_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q   <= 1'b0;
      filled_q <= '0;
      left_q   <= '0;
    end else if (swap) begin
      bank_q   <= ~bank_q;
      filled_q <= '0;
      left_q   <= '1;
    end else begin
      filled_q <= filled_q | fill_done;
      left_q   <= left_q & ~drain_done;
    end
  end

  assign fill_bank  = bank_q;
  assign drain_bank = ~bank_q;
  assign fill_hold  = filled_q;
  assign drain_act  = left_q;
endmodule

// File: rtl/ct_scatter_path.sv
module ct_scatter_path #(
  parameter int SW     = 32,
  parameter int LANES  = 2,
  parameter int SLOTS  = 4,
  parameter int POINTS = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANES*SW-1:0]         in_data,
  output logic [SLOTS-1:0]            cons_valid,
  input  logic [SLOTS-1:0]            cons_ready,
  output logic [SLOTS-1:0][SW-1:0]    cons_data,
  output logic [SLOTS-1:0]            cons_last
);
  localparam int PW    = ct_pkg::idx_w(POINTS);
  localparam int LW    = ct_pkg::idx_w(LANES);
  localparam int SLW   = ct_pkg::idx_w(SLOTS);
  localparam int DEPTH = 2 * POINTS;
  localparam int AW    = ct_pkg::idx_w(DEPTH);
  localparam logic [PW-1:0]  P_MAX = PW'(POINTS - 1);
  localparam logic [LW-1:0]  L_MAX = LW'(LANES - 1);
  localparam logic [SLW-1:0] S_MAX = SLW'(SLOTS - 1);

  function automatic logic [AW-1:0] bank_addr(input logic b, input logic [PW-1:0] p);
    return (b ? AW'(POINTS) : AW'(0)) + AW'(p);
  endfunction

  logic                            fill_bank, drain_bank;
  logic [0:0]                      fill_hold, fill_done;
  logic [SLOTS-1:0]                drain_act, drain_done;
  logic [SLOTS-1:0][LANES-1:0][SW-1:0] sq;

  ct_pingpong_ctrl #(.NF(1), .ND(SLOTS)) u_ctrl (
    .clk(clk), .rst(rst),
    .fill_done(fill_done), .drain_done(drain_done),
    .fill_bank(fill_bank), .drain_bank(drain_bank),
    .fill_hold(fill_hold), .drain_act(drain_act)
  );

  // beat writer: slot fastest, then point
  logic [PW-1:0]  wr_p;
  logic [SLW-1:0] wr_s;
  logic           accept;

  assign in_ready     = ~fill_hold[0];
  assign accept       = in_valid && in_ready;
  assign fill_done[0] = accept && (wr_s == S_MAX) && (wr_p == P_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p <= '0;
      wr_s <= '0;
    end else if (accept) begin
      if (wr_s == S_MAX) begin
        wr_s <= '0;
        wr_p <= (wr_p == P_MAX) ? '0 : wr_p + 1'b1;
      end else begin
        wr_s <= wr_s + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [PW-1:0] rd_p;
    logic [LW-1:0] rd_l, lane_q;
    logic          ov_q, last_q, issue;

    assign issue         = drain_act[s] && (!ov_q || cons_ready[s]);
    assign drain_done[s] = issue && (rd_l == L_MAX) && (rd_p == P_MAX);

    ct_sdp_ram #(.W(LANES*SW), .DEPTH(DEPTH)) u_ram (
      .clk(clk),
      .we(accept && (wr_s == SLW'(s))),
      .waddr(bank_addr(fill_bank, wr_p)),
      .wdata(in_data),
      .re(issue),
      .raddr(bank_addr(drain_bank, rd_p)),
      .rdata(sq[s])
    );

    // reader: point fastest, then lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_p   <= '0;
        rd_l   <= '0;
        lane_q <= '0;
        ov_q   <= 1'b0;
        last_q <= 1'b0;
      end else begin
        if (issue) begin
          ov_q   <= 1'b1;
          lane_q <= rd_l;
          last_q <= (rd_p == P_MAX);
          if (rd_p == P_MAX) begin
            rd_p <= '0;
            rd_l <= (rd_l == L_MAX) ? '0 : rd_l + 1'b1;
          end else begin
            rd_p <= rd_p + 1'b1;
          end
        end else if (cons_ready[s]) begin
          ov_q <= 1'b0;
        end
      end
    end

    assign cons_valid[s] = ov_q;
    assign cons_last[s]  = last_q;
    assign cons_data[s]  = sq[s][lane_q];
  end
endmodule

// File: rtl/ct_gather_path.sv
module ct_gather_path #(
  parameter int SW     = 32,
  parameter int LANES  = 2,
  parameter int SLOTS  = 4,
  parameter int POINTS = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLOTS-1:0]            res_valid,
  output logic [SLOTS-1:0]            res_ready,
  input  logic [SLOTS-1:0][SW-1:0]    res_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANES*SW-1:0]         out_data
);
  localparam int PW    = ct_pkg::idx_w(POINTS);
  localparam int LW    = ct_pkg::idx_w(LANES);
  localparam int SLW   = ct_pkg::idx_w(SLOTS);
  localparam int DEPTH = 2 * POINTS;
  localparam int AW    = ct_pkg::idx_w(DEPTH);
  localparam logic [PW-1:0]  P_MAX = PW'(POINTS - 1);
  localparam logic [LW-1:0]  L_MAX = LW'(LANES - 1);
  localparam logic [SLW-1:0] S_MAX = SLW'(SLOTS - 1);

  function automatic logic [AW-1:0] bank_addr(input logic b, input logic [PW-1:0] p);
    return (b ? AW'(POINTS) : AW'(0)) + AW'(p);
  endfunction

  logic                                fill_bank, drain_bank;
  logic [SLOTS-1:0]                    fill_hold, fill_done;
  logic [0:0]                          drain_act, drain_done;
  logic [SLOTS-1:0][LANES-1:0][SW-1:0] gq;

  ct_pingpong_ctrl #(.NF(SLOTS), .ND(1)) u_ctrl (
    .clk(clk), .rst(rst),
    .fill_done(fill_done), .drain_done(drain_done),
    .fill_bank(fill_bank), .drain_bank(drain_bank),
    .fill_hold(fill_hold), .drain_act(drain_act)
  );

  // beat reader: slot fastest, then point
  logic [PW-1:0]  rd_p;
  logic [SLW-1:0] rd_s, sel_q;
  logic           ov_q, issue;

  assign issue         = drain_act[0] && (!ov_q || out_ready);
  assign drain_done[0] = issue && (rd_s == S_MAX) && (rd_p == P_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p  <= '0;
      rd_s  <= '0;
      sel_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      if (issue) begin
        ov_q  <= 1'b1;
        sel_q <= rd_s;
        if (rd_s == S_MAX) begin
          rd_s <= '0;
          rd_p <= (rd_p == P_MAX) ? '0 : rd_p + 1'b1;
        end else begin
          rd_s <= rd_s + 1'b1;
        end
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = gq[sel_q];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [PW-1:0] wp;
    logic [LW-1:0] wl;
    logic          acc;

    assign res_ready[s] = ~fill_hold[s];
    assign acc          = res_valid[s] && res_ready[s];
    assign fill_done[s] = acc && (wl == L_MAX) && (wp == P_MAX);

    // port writer: point fastest, then lane
    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        wl <= '0;
      end else if (acc) begin
        if (wp == P_MAX) begin
          wp <= '0;
          wl <= (wl == L_MAX) ? '0 : wl + 1'b1;
        end else begin
          wp <= wp + 1'b1;
        end
      end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      ct_sdp_ram #(.W(SW), .DEPTH(DEPTH)) u_ram (
        .clk(clk),
        .we(acc && (wl == LW'(l))),
        .waddr(bank_addr(fill_bank, wp)),
        .wdata(res_data[s]),
        .re(issue && (rd_s == SLW'(s))),
        .raddr(bank_addr(drain_bank, rd_p)),
        .rdata(gq[s][l])
      );
    end
  end
endmodule

// File: rtl/ilv_corner_turn.sv
module ilv_corner_turn #(
  parameter int SW     = ct_pkg::SAMPLE_W_DEF,
  parameter int LANES  = ct_pkg::LANES_DEF,
  parameter int SLOTS  = ct_pkg::SLOTS_DEF,
  parameter int POINTS = ct_pkg::POINTS_DEF
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANES*SW-1:0]         in_data,
  output logic [SLOTS-1:0]            cons_valid,
  input  logic [SLOTS-1:0]            cons_ready,
  output logic [SLOTS-1:0][SW-1:0]    cons_data,
  output logic [SLOTS-1:0]            cons_last,
  input  logic [SLOTS-1:0]            res_valid,
  output logic [SLOTS-1:0]            res_ready,
  input  logic [SLOTS-1:0][SW-1:0]    res_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANES*SW-1:0]         out_data
);
  ct_scatter_path #(.SW(SW), .LANES(LANES), .SLOTS(SLOTS), .POINTS(POINTS)) u_scatter (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cons_valid(cons_valid), .cons_ready(cons_ready),
    .cons_data(cons_data), .cons_last(cons_last)
  );

  ct_gather_path #(.SW(SW), .LANES(LANES), .SLOTS(SLOTS), .POINTS(POINTS)) u_gather (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/ilv_corner_turn_chk.sv
module ilv_corner_turn_chk #(
  parameter int SW     = 32,
  parameter int LANES  = 2,
  parameter int SLOTS  = 4,
  parameter int POINTS = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [SLOTS-1:0]         cons_valid,
  input logic [SLOTS-1:0]         cons_ready,
  input logic [SLOTS-1:0][SW-1:0] cons_data,
  input logic [SLOTS-1:0]         cons_last,
  input logic [SLOTS-1:0]         res_valid,
  input logic [SLOTS-1:0]         res_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [LANES*SW-1:0]      out_data
);
  localparam int PW = ct_pkg::idx_w(POINTS);
  localparam logic [PW-1:0] P_MAX = PW'(POINTS - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && (&res_ready) && !out_valid && (cons_valid == '0))); // R1

  AST_IN_READY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> $past(in_valid && in_ready)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  for (genvar k = 0; k < SLOTS; k++) begin : g_port
    logic [PW-1:0] seen;

    always_ff @(posedge clk) begin
      if (rst) seen <= '0;
      else if (cons_valid[k] && cons_ready[k])
        seen <= (seen == P_MAX) ? '0 : seen + 1'b1;
    end

    AST_LAST_POS: assert property (@(posedge clk) disable iff (rst)
      (cons_valid[k] && cons_ready[k]) |-> (cons_last[k] == (seen == P_MAX))); // R4

    AST_CONS_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cons_valid[k] && !cons_ready[k]) |=>
        (cons_valid[k] && $stable(cons_data[k]) && $stable(cons_last[k]))); // R9

    AST_RES_READY_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(res_ready[k]) |-> $past(res_valid[k] && res_ready[k])); // R7
  end
endmodule

bind ilv_corner_turn ilv_corner_turn_chk #(
  .SW(SW), .LANES(LANES), .SLOTS(SLOTS), .POINTS(POINTS)
) u_chk (
  .clk(clk), .rst(rst),
  .in_valid(in_valid), .in_ready(in_ready),
  .cons_valid(cons_valid), .cons_ready(cons_ready),
  .cons_data(cons_data), .cons_last(cons_last),
  .res_valid(res_valid), .res_ready(res_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/ilv_corner_turn_tb_top.sv
`timescale 1ns/1ps
module ilv_corner_turn_tb_top;
  localparam int P = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [63:0]       in_data = '0;
  logic [3:0]        cons_valid, cons_ready, cons_last;
  logic [3:0][31:0]  cons_data;
  logic [3:0]        res_valid, res_ready;
  logic [3:0][31:0]  res_data;
  logic              out_valid, out_ready;
  logic [63:0]       out_data;

  always #4 clk = ~clk;

  ilv_corner_turn #(.SW(32), .LANES(2), .SLOTS(4), .POINTS(P)) dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cons_valid(cons_valid), .cons_ready(cons_ready),
    .cons_data(cons_data), .cons_last(cons_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // identity kernels with optional stalls
  logic [15:0] lfsr = 16'hACE1;
  logic        hold_all = 1'b0;
  logic        stall_en = 1'b0;
  logic [3:0]  gate;
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign gate       = hold_all ? 4'h0 : (stall_en ? (lfsr[3:0] | lfsr[7:4]) : 4'hF);
  assign out_ready  = hold_all ? 1'b0 : (stall_en ? (lfsr[9] | lfsr[10]) : 1'b1);
  assign cons_ready = res_ready & gate;
  assign res_valid  = cons_valid & gate;
  assign res_data   = cons_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int port_cnt [4];
  int beat_cnt = 0;

  logic [31:0] port_q [4][$];
  logic [63:0] out_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sample: [31:24] buffer, [23:20] lane, [19:16] slot, [15:0] point
  function automatic logic [31:0] enc(input int b, input int l, input int s, input int p);
    return {8'(b), 4'(l), 4'(s), 16'(p)};
  endfunction

  task automatic send_beat(input logic [63:0] beat, input bit gaps);
    bit acc;
    if (gaps && lfsr[12]) @(negedge clk);
    in_valid = 1'b1;
    in_data  = beat;
    do begin
      #3;
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic send_buffer(input int b, input bit gaps);
    for (int k = 0; k < 4; k++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < P; p++)
          port_q[k].push_back(enc(b, l, k, p));
    for (int p = 0; p < P; p++)
      for (int s = 0; s < 4; s++) begin
        logic [63:0] beat;
        beat = {enc(b, 1, s, p), enc(b, 0, s, p)};
        out_q.push_back(beat);
        send_beat(beat, gaps);
      end
  endtask

  // scoreboard monitor, one ns before each rising edge
  logic [3:0]       prev_stall;
  logic [3:0][31:0] prev_data;
  logic [3:0]       prev_last;
  logic             prev_ostall = 1'b0;
  logic [63:0]      prev_odata;
  initial begin
    prev_stall = '0;
    forever begin
      @(negedge clk); #3;
      if (!rst) begin
        for (int k = 0; k < 4; k++) begin
          if (prev_stall[k])
            chk(cons_valid[k] && cons_data[k] == prev_data[k] && cons_last[k] == prev_last[k],
                "R9 stalled consumer sample held", {cons_last[k], cons_data[k]}, {prev_last[k], prev_data[k]});
          prev_stall[k] = cons_valid[k] && !cons_ready[k];
          prev_data[k]  = cons_data[k];
          prev_last[k]  = cons_last[k];
          if (cons_valid[k] && cons_ready[k]) begin
            port_cnt[k]++;
            if (port_q[k].size() == 0) begin
              chk(1'b0, "R3 unexpected consumer sample", {32'd0, cons_data[k]}, 64'd0);
            end else begin
              logic [31:0] e;
              e = port_q[k].pop_front();
              chk(cons_data[k] == e, "R2 R3 consumer port order", {32'd0, cons_data[k]}, {32'd0, e});
              chk(cons_last[k] == (e[15:0] == 16'(P - 1)), "R4 last flag position",
                  {63'd0, cons_last[k]}, {63'd0, (e[15:0] == 16'(P - 1))});
            end
          end
        end
        if (prev_ostall)
          chk(out_valid && out_data == prev_odata, "R10 stalled output beat held", out_data, prev_odata);
        prev_ostall = out_valid && !out_ready;
        prev_odata  = out_data;
        if (out_valid && out_ready) begin
          beat_cnt++;
          if (out_q.size() == 0) begin
            chk(1'b0, "R8 unexpected output beat", out_data, 64'd0);
          end else begin
            logic [63:0] e;
            e = out_q.pop_front();
            chk(out_data == e, "R7 R8 round-trip beat order", out_data, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #3;
    chk(in_ready == 1'b1, "R1 in_ready after reset", {63'd0, in_ready}, 64'd1);
    chk(res_ready == 4'hF, "R1 res_ready after reset", {60'd0, res_ready}, 64'hF);
    chk(cons_valid == 4'h0, "R1 cons_valid after reset", {60'd0, cons_valid}, 64'd0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    @(negedge clk);

    // fill both halves with every consumer blocked
    hold_all = 1'b1;
    send_buffer(0, 1'b0);
    send_buffer(1, 1'b0);
    repeat (10) @(negedge clk);
    #3;
    chk(in_ready == 1'b0, "R6 back-pressure with both halves occupied", {63'd0, in_ready}, 64'd0);
    chk(cons_valid == 4'hF, "R5 ports hold first half while second filled", {60'd0, cons_valid}, 64'hF);
    chk(out_valid == 1'b0, "R8 no output before any result", {63'd0, out_valid}, 64'd0);
    @(negedge clk);

    // random stalls and input gaps
    hold_all = 1'b0;
    stall_en = 1'b1;
    for (int b = 2; b < 6; b++) send_buffer(b, 1'b1);
    // gap-free traffic, writes and reads on opposite banks every edge
    stall_en = 1'b0;
    for (int b = 6; b < 9; b++) send_buffer(b, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (out_q.size() == 0 && port_q[0].size() == 0 && port_q[1].size() == 0 &&
          port_q[2].size() == 0 && port_q[3].size() == 0) break;
    end
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++)
      chk(port_cnt[k] == 9 * 2 * P, "R3 samples per consumer port", 64'(port_cnt[k]), 64'(9 * 2 * P));
    chk(beat_cnt == 9 * 4 * P, "R8 output beats returned", 64'(beat_cnt), 64'(9 * 4 * P));
    chk(out_q.size() == 0, "R7 R8 no missing output beats", 64'(out_q.size()), 64'd0);
    chk(in_ready == 1'b1, "R6 in_ready restored when drained", {63'd0, in_ready}, 64'd1);
    chk(res_ready == 4'hF, "R7 result ports open after swap", {60'd0, res_ready}, 64'hF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule